// File: doc/BRIEF.md
# Control-Code Repeat Decoder

This block watches one already-selected channel of a 1-bit pulse-density audio stream and recognises command patterns hidden in it. A command is an 8-bit pattern, sent least significant bit first, that decodes to silence as audio. The host repeats the pattern back to back. The block finds the byte alignment on its own by comparing a sliding 8-bit window against the code table on every bit. Once it has locked, it counts how many identical codes arrive exactly 8 bits apart. When a count reaches the threshold for that code, the block emits a one-cycle command event or updates a configuration register.

A one-shot prefix code switches the meaning of the next command to a second page. On that page, three codes toggle or increment mode bits instead of writing them. Configuration changes are taken only while the surrounding device reports that it is in standby. Loss of the stream clock, signalled on `clk_lost`, restores every default and drops alignment and page state.

Two finite-state machines carry the behaviour:

- **Tracker** (states `TRK_HUNT` and `TRK_LOCKED`).
  - HUNT→LOCKED on the first window that matches a code.
  - LOCKED→LOCKED on a matching boundary. The boundary is the 8th bit after the previous match.
  - LOCKED→HUNT when that boundary window is not a code.
  - Any state→HUNT on `clk_lost`.
- **Page** (states `PG_PRIMARY` and `PG_SECONDARY`).
  - PRIMARY→SECONDARY when the page-access code reaches its threshold in standby.
  - SECONDARY→PRIMARY on the next code that reaches the command threshold.
  - Any state→PRIMARY on `clk_lost`.

Top module: `ctlseq_decoder`

## Requirements
- R1: A code counts as a repeat only when it matches at the window exactly 8 strobed bits after the previous match. A non-code window at that position resets the count and returns to hunting. A different code at that position restarts the count at 1.
- R2: Ordinary commands act on the 33rd consecutive identical code (CODE_REPS). With 32 repeats nothing happens.
- R3: On page 1, code 0xAA raises `ev_fast_start` on its 4th consecutive repeat (FAST_REPS).
- R4: On page 1, at the command threshold, 0x66 raises `ev_standby`, 0xD4 raises `ev_start_3v6` and 0xD8 raises `ev_start_5v0`. These three act whatever `in_standby` is.
- R5: `ev_any_64` pulses on the 64th consecutive repeat of any table code. This includes the reserved codes 0xD1 and 0xD2, which have no other effect.
- R6: Each event pulses for one cycle, at most once per run of identical codes. It can fire again only after a different code or non-code data.
- R7: Code 0x56 on page 1, taken in standby, makes only the next code that reaches the command threshold use page 2. Later codes use page 1 again.
- R8: On page 1, in standby: 0xF0 inverts `slew_sel[1]`, 0x8B sets `rate_32k`, and 0x39 clears `hpf_en`.
- R9: On page 2, in standby: 0xF0 inverts `perf1`, 0xD4 inverts `slew_sel[0]`, and 0xD8 increments `perf2`, wrapping from 11 to 00. All other page-2 codes are reserved.
- R10: While `in_standby` is low, no configuration output changes and 0x56 does not arm page 2.
- R11: After reset or a `clk_lost` pulse, the outputs hold their defaults: `slew_sel`=01 (00/01/10/11 select the 5/10/20/40 ns edge rates), `perf1`=1, `perf2`=01, `hpf_en`=1 and `rate_32k`=0. The same pulse also clears alignment, the repeat count and the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdm_bit | input | 1 | Selected channel data bit |
| pdm_stb | input | 1 | One-cycle strobe qualifying `pdm_bit` |
| clk_lost | input | 1 | Stream clock has stopped; restore defaults |
| in_standby | input | 1 | Device is in standby; configuration permitted |
| ev_fast_start | output | 1 | Fast start-up command pulse |
| ev_start_3v6 | output | 1 | Start-up for the lower supply pulse |
| ev_start_5v0 | output | 1 | Start-up for the higher supply pulse |
| ev_standby | output | 1 | Standby command pulse |
| ev_any_64 | output | 1 | 64 consecutive repeats of any code |
| slew_sel | output | 2 | Output edge-rate selection |
| perf1 | output | 1 | Operating-mode bit (0 selects best SNR) |
| perf2 | output | 2 | Operating-mode field (00 with perf1=1 selects best PSRR) |
| hpf_en | output | 1 | Input high-pass filter enable |
| rate_32k | output | 1 | 32 kHz sample-rate mode |

## Verification
The hardest case to reach from the ports is a broken alignment inside a long run of one code. The stream carries 20 copies of 0xD8, then one extra bit, then 20 more copies. Because of the extra bit, the tracker must hunt and lock again, and the 40 copies must never add up to a start-up event. The second hard case is the page-2 one-shot. A 0xD4 run taken on page 2 is followed by a second 0xD4 run. The first run must only flip a slew bit. The second must raise the start-up event, which shows that the page has fallen back to page 1. A scoreboard queue holds every expected event pulse, so any extra pulse from a saturated count or a leftover page flag shows up as a mismatch.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [3:0] {
        CID_NONE, CID_AA, CID_66, CID_F0, CID_8B, CID_39,
        CID_56, CID_D1, CID_D2, CID_D4, CID_D8
    } code_id_e;

    typedef enum logic { TRK_HUNT, TRK_LOCKED } trk_state_e;

    typedef enum logic { PG_PRIMARY, PG_SECONDARY } page_state_e;

    function automatic code_id_e code_lookup(input logic [CODE_W-1:0] w);
        code_id_e r;
        case (w)
            8'hAA:   r = CID_AA;
            8'h66:   r = CID_66;
            8'hF0:   r = CID_F0;
            8'h8B:   r = CID_8B;
            8'h39:   r = CID_39;
            8'h56:   r = CID_56;
            8'hD1:   r = CID_D1;
            8'hD2:   r = CID_D2;
            8'hD4:   r = CID_D4;
            8'hD8:   r = CID_D8;
            default: r = CID_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ctlseq_shifter.sv
module ctlseq_shifter
    import ctlseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     bit_in,
    input  logic     stb,
    output code_id_e id_now
);
    logic [CODE_W-1:0] win_q;
    logic [CODE_W-1:0] win_nxt;

    // First-received bit ends up in bit 0 after CODE_W strobes.
    assign win_nxt = {bit_in, win_q[CODE_W-1:1]};
    assign id_now  = stb ? code_lookup(win_nxt) : CID_NONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_q <= '0;
        else if (clr)    win_q <= '0;
        else if (stb)    win_q <= win_nxt;
    end

endmodule

// File: rtl/ctlseq_tracker.sv
module ctlseq_tracker
    import ctlseq_pkg::*;
#(
    parameter int SAT = 64,
    localparam int CW = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          stb,
    input  code_id_e      id_in,
    output logic          step,
    output code_id_e      cur,
    output logic [CW-1:0] cnt
);
    localparam int PW = $clog2(CODE_W);
    localparam logic [PW-1:0] PH_LAST = PW'(CODE_W - 1);
    localparam logic [CW-1:0] SAT_C   = CW'(SAT);

    trk_state_e    st_q, st_nxt;
    logic [PW-1:0] phase_q;
    logic          boundary;

    assign boundary = stb && (st_q == TRK_LOCKED) && (phase_q == PH_LAST);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TRK_HUNT:   if (stb && id_in != CID_NONE) st_nxt = TRK_LOCKED;
            TRK_LOCKED: if (boundary && id_in == CID_NONE) st_nxt = TRK_HUNT;
            default:    st_nxt = TRK_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= TRK_HUNT;
        else if (clr) st_q <= TRK_HUNT;
        else          st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= 1'b0; cur <= CID_NONE; cnt <= '0; phase_q <= '0;
        end else if (clr) begin
            step <= 1'b0; cur <= CID_NONE; cnt <= '0; phase_q <= '0;
        end else begin
            step <= 1'b0;
            unique case (st_q)
                TRK_HUNT: begin
                    if (stb && id_in != CID_NONE) begin
                        cur <= id_in; cnt <= CW'(1); step <= 1'b1; phase_q <= '0;
                    end
                end
                TRK_LOCKED: begin
                    if (stb) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                    if (boundary) begin
                        if (id_in == CID_NONE) begin
                            cur <= CID_NONE; cnt <= '0;
                        end else if (id_in == cur) begin
                            if (cnt < SAT_C) begin
                                cnt <= cnt + 1'b1; step <= 1'b1;
                            end
                        end else begin
                            cur <= id_in; cnt <= CW'(1); step <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_HUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_HUNT) |-> (cnt == '0)); // R1
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SAT_C); // R5
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt == CW'(1) || cnt == CW'($past(cnt) + 1'b1))); // R6

endmodule

// File: rtl/ctlseq_cfg.sv
module ctlseq_cfg
    import ctlseq_pkg::*;
#(
    parameter int FAST_REPS = 4,
    parameter int CODE_REPS = 33,
    parameter int ANY_REPS  = 64,
    localparam int CW = $clog2(ANY_REPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          standby,
    input  logic          step,
    input  code_id_e      id,
    input  logic [CW-1:0] cnt,
    output logic          ev_fast,
    output logic          ev_lo,
    output logic          ev_hi,
    output logic          ev_stby,
    output logic          ev_any,
    output logic [1:0]    slew,
    output logic          pc1,
    output logic [1:0]    pc2,
    output logic          hpf,
    output logic          m32
);
    localparam logic [CW-1:0] FAST_C = CW'(FAST_REPS);
    localparam logic [CW-1:0] CMD_C  = CW'(CODE_REPS);
    localparam logic [CW-1:0] ANY_C  = CW'(ANY_REPS);

    page_state_e pg_q, pg_nxt;
    logic        cmd_hit;

    assign cmd_hit = step && (cnt == CMD_C);

    always_comb begin
        pg_nxt = pg_q;
        unique case (pg_q)
            PG_PRIMARY:   if (cmd_hit && id == CID_56 && standby) pg_nxt = PG_SECONDARY;
            PG_SECONDARY: if (cmd_hit) pg_nxt = PG_PRIMARY;
            default:      pg_nxt = PG_PRIMARY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pg_q <= PG_PRIMARY;
        else if (clr) pg_q <= PG_PRIMARY;
        else          pg_q <= pg_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ev_fast, ev_lo, ev_hi, ev_stby, ev_any} <= '0;
            slew <= 2'b01; pc1 <= 1'b1; pc2 <= 2'b01; hpf <= 1'b1; m32 <= 1'b0;
        end else if (clr) begin
            {ev_fast, ev_lo, ev_hi, ev_stby, ev_any} <= '0;
            slew <= 2'b01; pc1 <= 1'b1; pc2 <= 2'b01; hpf <= 1'b1; m32 <= 1'b0;
        end else begin
            {ev_fast, ev_lo, ev_hi, ev_stby, ev_any} <= '0;
            if (step && cnt == FAST_C && id == CID_AA && pg_q == PG_PRIMARY)
                ev_fast <= 1'b1;
            if (step && cnt == ANY_C)
                ev_any <= 1'b1;
            if (cmd_hit) begin
                if (pg_q == PG_SECONDARY) begin
                    if (standby) begin
                        case (id)
                            CID_F0:  pc1     <= ~pc1;
                            CID_D4:  slew[0] <= ~slew[0];
                            CID_D8:  pc2     <= pc2 + 1'b1;
                            default: ;
                        endcase
                    end
                end else begin
                    case (id)
                        CID_66:  ev_stby <= 1'b1;
                        CID_D4:  ev_lo   <= 1'b1;
                        CID_D8:  ev_hi   <= 1'b1;
                        CID_F0:  if (standby) slew[1] <= ~slew[1];
                        CID_8B:  if (standby) m32 <= 1'b1;
                        CID_39:  if (standby) hpf <= 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_PAGE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q == PG_SECONDARY && cmd_hit && !clr) |=> (pg_q == PG_PRIMARY)); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && !clr) |=> $stable({slew, pc1, pc2, hpf, m32})); // R10
    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_fast, ev_lo, ev_hi, ev_stby, ev_any})); // R6
    AST_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pg_q == PG_PRIMARY && slew == 2'b01 && pc1 && pc2 == 2'b01 && hpf && !m32)); // R11

endmodule

// File: rtl/ctlseq_decoder.sv
module ctlseq_decoder
    import ctlseq_pkg::*;
#(
    parameter int FAST_REPS = 4,
    parameter int CODE_REPS = 33,
    parameter int ANY_REPS  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdm_bit,
    input  logic       pdm_stb,
    input  logic       clk_lost,
    input  logic       in_standby,
    output logic       ev_fast_start,
    output logic       ev_start_3v6,
    output logic       ev_start_5v0,
    output logic       ev_standby,
    output logic       ev_any_64,
    output logic [1:0] slew_sel,
    output logic       perf1,
    output logic [1:0] perf2,
    output logic       hpf_en,
    output logic       rate_32k
);
    localparam int CW = $clog2(ANY_REPS + 1);

    code_id_e      id_now;
    code_id_e      cur_id;
    logic          step;
    logic [CW-1:0] cnt;

    ctlseq_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clk_lost),
        .bit_in(pdm_bit), .stb(pdm_stb), .id_now(id_now)
    );

    ctlseq_tracker #(.SAT(ANY_REPS)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(clk_lost), .stb(pdm_stb),
        .id_in(id_now), .step(step), .cur(cur_id), .cnt(cnt)
    );

    ctlseq_cfg #(.FAST_REPS(FAST_REPS), .CODE_REPS(CODE_REPS), .ANY_REPS(ANY_REPS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .clr(clk_lost), .standby(in_standby),
        .step(step), .id(cur_id), .cnt(cnt),
        .ev_fast(ev_fast_start), .ev_lo(ev_start_3v6), .ev_hi(ev_start_5v0),
        .ev_stby(ev_standby), .ev_any(ev_any_64),
        .slew(slew_sel), .pc1(perf1), .pc2(perf2), .hpf(hpf_en), .m32(rate_32k)
    );

endmodule

// File: tb/ctlseq_decoder_test.sv
`timescale 1ns/1ps
module ctlseq_decoder_test;

    localparam int EV_FAST = 0, EV_LO = 1, EV_HI = 2, EV_STBY = 3, EV_ANY = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, pdm_bit, pdm_stb, clk_lost, in_standby;
    logic ev_fast_start, ev_start_3v6, ev_start_5v0, ev_standby, ev_any_64;
    logic [1:0] slew_sel, perf2;
    logic perf1, hpf_en, rate_32k;

    ctlseq_decoder uut (
        .clk(clk), .rst_n(rst_n), .pdm_bit(pdm_bit), .pdm_stb(pdm_stb),
        .clk_lost(clk_lost), .in_standby(in_standby),
        .ev_fast_start(ev_fast_start), .ev_start_3v6(ev_start_3v6),
        .ev_start_5v0(ev_start_5v0), .ev_standby(ev_standby), .ev_any_64(ev_any_64),
        .slew_sel(slew_sel), .perf1(perf1), .perf2(perf2), .hpf_en(hpf_en),
        .rate_32k(rate_32k)
    );

    typedef struct { int id; string req; } exp_t;
    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;

    task automatic expect_ev(input int id, input string req);
        exp_t e;
        e.id = id; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: pops the scoreboard on every observed event pulse.
    always @(negedge clk) begin
        logic [4:0] ev;
        ev = {ev_any_64, ev_standby, ev_start_5v0, ev_start_3v6, ev_fast_start};
        if (rst_n) begin
            for (int i = 0; i < 5; i++) begin
                if (ev[i]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R6: event %0d seen, expected none", i);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (e.id != i) begin
                            fails++;
                            $display("FAIL %s: event %0d seen, expected %0d", e.req, i, e.id);
                        end
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); pdm_stb = 1'b1; pdm_bit = b;
        @(negedge clk); pdm_stb = 1'b0;
    endtask

    task automatic send_code(input logic [7:0] c, input int n);
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++) send_bit(c[b]);
    endtask

    task automatic sep();
        send_code(8'h00, 1);
        idle(6);
    endtask

    task automatic run(input logic [7:0] c, input int n);
        send_code(c, n);
        sep();
    endtask

    task automatic check_empty(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected events missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic check_cfg(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {slew_sel, perf1, perf2, hpf_en, rate_32k};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cfg=%b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pdm_bit = 1'b0; pdm_stb = 1'b0; clk_lost = 1'b0; in_standby = 1'b1;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R11 reset defaults: slew 01, pc1 1, pc2 01, hpf 1, m32 0
        check_cfg("R11 reset", 7'b01_1_01_1_0);

        // R3 fast start at 4 repeats, R5 any-code at 64
        expect_ev(EV_FAST, "R3");
        expect_ev(EV_ANY, "R5");
        run(8'hAA, 70);
        check_empty("R3");

        // R2: 32 repeats do nothing, 33 act
        run(8'h66, 32);
        check_empty("R2");
        expect_ev(EV_STBY, "R2");
        run(8'h66, 33);
        check_empty("R4");

        // R8 page-1 configuration in standby
        run(8'hF0, 33);
        check_cfg("R8 slew1", 7'b11_1_01_1_0);
        run(8'h8B, 33);
        run(8'h39, 33);
        check_cfg("R8 rate/hpf", 7'b11_1_01_0_1);

        // R9 page-2 configuration
        run(8'h56, 33); run(8'hD4, 33);
        check_cfg("R9 slew0", 7'b10_1_01_0_1);
        run(8'h56, 33); run(8'hD8, 33);
        run(8'h56, 33); run(8'hD8, 33);
        run(8'h56, 33); run(8'hD8, 33);
        check_cfg("R9 pc2 wrap", 7'b10_1_00_0_1);
        run(8'h56, 33); run(8'hF0, 33);
        check_cfg("R9 pc1", 7'b10_0_00_0_1);

        // R7 page 2 lasts for one command only
        run(8'h56, 33); run(8'hD4, 33);
        check_empty("R7 no start on page2");
        expect_ev(EV_LO, "R7");
        run(8'hD4, 33);
        check_cfg("R7", 7'b11_0_00_0_1);
        check_empty("R7");

        // R5 reserved code still reaches the 64-repeat event
        expect_ev(EV_ANY, "R5");
        run(8'hD1, 64);
        check_empty("R5");

        // R1 broken alignment restarts the count
        send_code(8'hD8, 20);
        send_bit(1'b0);
        send_code(8'hD8, 20);
        sep();
        check_empty("R1");

        // R10 nothing configurable outside standby; R4 commands still act
        in_standby = 1'b0;
        run(8'hF0, 33); run(8'h8B, 33); run(8'h56, 33);
        expect_ev(EV_LO, "R10");
        run(8'hD4, 33);
        check_cfg("R10", 7'b11_0_00_0_1);
        expect_ev(EV_HI, "R4");
        run(8'hD8, 33);
        expect_ev(EV_STBY, "R4");
        run(8'h66, 33);
        check_empty("R4");

        // R11 clock loss restores defaults and clears the repeat count
        @(negedge clk); clk_lost = 1'b1;
        @(negedge clk); clk_lost = 1'b0;
        idle(2);
        check_cfg("R11 clk_lost", 7'b01_1_01_1_0);
        send_code(8'hAA, 2);
        @(negedge clk); clk_lost = 1'b1;
        @(negedge clk); clk_lost = 1'b0;
        send_code(8'hAA, 2);
        sep();
        check_empty("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule